// File: doc/BRIEF.md
# I2C Event Status Register

This block is the primary status word of a two-wire serial bus controller that also speaks the system-management variant of the protocol. The protocol engine reports single-cycle event pulses and steady level indications. This block turns the error pulses into sticky flags that software can read and clear. It passes the level indications through as read-only bits. The word sits at a fixed offset, 0x14 by default, on a simple register read/write port.

An error flag is set by its event pulse. Software clears it by writing 0 to its bit position, and writing 1 leaves it alone. The alert flag and the timeout flag are also forced clear by hardware while the peripheral enable is low. The alert flag has two possible sources, and the one used depends on the mode. In host mode it is set by an event on the alert pin. In device mode it is set by reception of the alert response address header.

Top module: `i2c_evt_status`

## Requirements
- R1: After a synchronous reset, a read of the status word returns 0x0000.
- R2: Each error event pulse sets its flag, and the flag stays set once the pulse ends. The flags and their bit positions are: timeout bit 14, CRC error bit 12, overrun bit 11, not-acknowledged bit 10, arbitration lost bit 9 and bus error bit 8.
- R3: A write to the status offset clears every error flag (bits 15, 14, 12, 11, 10, 9, 8) whose data bit is 0. Error flags whose data bit is 1 are left unchanged.
- R4: When an event pulse arrives in the same cycle as a write that would clear its flag, the flag ends up set.
- R5: Read-only bits follow their level inputs, with one register stage of delay, and writes never change them. The bits are: transmit empty bit 7, receive full bit 6, stop seen bit 4, 10-bit header sent bit 3, byte done bit 2, address matched bit 1 and start sent bit 0.
- R6: Bit 15 (alert) is set by evt_alert_pin when host_mode=1 and by evt_alert_hdr when host_mode=0. The source that is not selected has no effect.
- R7: While periph_en=0, bits 15 and 14 are cleared and held at 0, even when their events arrive. The other error flags keep their values.
- R8: Reserved bits 13 and 5 always read 0.
- R9: Writes to any address other than the status offset have no effect. A read returns data in reg_rdata on the cycle after reg_rd. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_en | input | 1 | Peripheral enable; low clears alert and timeout |
| host_mode | input | 1 | 1 = host mode, 0 = device mode (alert source select) |
| evt_alert_pin | input | 1 | Alert pin event pulse (host mode source) |
| evt_alert_hdr | input | 1 | Alert response header received pulse (device mode source) |
| evt_timeout | input | 1 | Clock-low timeout event pulse |
| evt_crc | input | 1 | Packet CRC mismatch event pulse |
| evt_overrun | input | 1 | Overrun/underrun event pulse |
| evt_nack | input | 1 | Acknowledge failure event pulse |
| evt_arb_lost | input | 1 | Arbitration lost event pulse |
| evt_bus_err | input | 1 | Misplaced start/stop event pulse |
| lvl_tx_empty | input | 1 | Transmit data register empty level |
| lvl_rx_full | input | 1 | Receive data register full level |
| lvl_stop | input | 1 | Stop detected level |
| lvl_hdr10 | input | 1 | 10-bit header sent level |
| lvl_byte_done | input | 1 | Byte transfer finished level |
| lvl_addr_match | input | 1 | Address sent/matched level |
| lvl_start | input | 1 | Start generated level |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |

## Verification
The hardest case to reach is an event pulse and a clearing write landing on the same clock edge. From the ports this looks just like an ordinary write, so the bench places both stimuli in one table step. It then checks that the pulsed flag survives while the other flags are cleared. A second hard case is an alert or timeout event arriving while the enable is low. The bench drives such events during the disabled window and reads the word before re-enabling. It also fires the unselected alert source in each mode, so a wrong mode mux shows up.

// File: rtl/i2c_sts_pkg.sv
package i2c_sts_pkg;

  localparam int STS_W = 16;
  localparam int ERR_N = 7;
  localparam int LVL_N = 7;

  // error flag order: 0 alert, 1 timeout, 2 crc, 3 overrun, 4 nack, 5 arb lost, 6 bus err
  function automatic int err_pos(input int idx);
    case (idx)
      0: err_pos = 15;
      1: err_pos = 14;
      2: err_pos = 12;
      3: err_pos = 11;
      4: err_pos = 10;
      5: err_pos = 9;
      default: err_pos = 8;
    endcase
  endfunction

  // level order: 0 tx empty, 1 rx full, 2 stop, 3 hdr10, 4 byte done, 5 addr match, 6 start
  function automatic int lvl_pos(input int idx);
    case (idx)
      0: lvl_pos = 7;
      1: lvl_pos = 6;
      2: lvl_pos = 4;
      3: lvl_pos = 3;
      4: lvl_pos = 2;
      5: lvl_pos = 1;
      default: lvl_pos = 0;
    endcase
  endfunction

  // flags that hardware clears while the peripheral is disabled
  function automatic bit err_hw_clr(input int idx);
    err_hw_clr = (idx < 2);
  endfunction

endpackage

// File: rtl/i2c_sts_alert_sel.sv
module i2c_sts_alert_sel (
  input  logic host_mode,
  input  logic pin_evt,
  input  logic hdr_evt,
  output logic alert_evt
);
  always_comb begin
    if (host_mode) alert_evt = pin_evt;
    else           alert_evt = hdr_evt;
  end
endmodule

// File: rtl/i2c_sts_sticky.sv
module i2c_sts_sticky #(
  parameter bit HW_CLR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic evt,
  input  logic sw_clr,
  output logic q
);
  logic dis_clr;
  assign dis_clr = HW_CLR && !en;

  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (dis_clr) q <= 1'b0;
    else if (evt)    q <= 1'b1;
    else if (sw_clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_sts_level_cap.sv
module i2c_sts_level_cap #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_in;
  end
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_sts_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              periph_en,
  input  logic              host_mode,
  input  logic              evt_alert_pin,
  input  logic              evt_alert_hdr,
  input  logic              evt_timeout,
  input  logic              evt_crc,
  input  logic              evt_overrun,
  input  logic              evt_nack,
  input  logic              evt_arb_lost,
  input  logic              evt_bus_err,
  input  logic              lvl_tx_empty,
  input  logic              lvl_rx_full,
  input  logic              lvl_stop,
  input  logic              lvl_hdr10,
  input  logic              lvl_byte_done,
  input  logic              lvl_addr_match,
  input  logic              lvl_start,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [15:0]       reg_rdata
);

  logic             alert_evt;
  logic [ERR_N-1:0] err_evt;
  logic [ERR_N-1:0] err_q;
  logic [LVL_N-1:0] lvl_in;
  logic [LVL_N-1:0] lvl_q;
  logic             wr_hit;
  logic             rd_hit;
  logic [STS_W-1:0] sts_q;

  assign wr_hit = reg_wr && (reg_addr == REG_OFS);
  assign rd_hit = reg_rd && (reg_addr == REG_OFS);

  i2c_sts_alert_sel u_alert_sel (
    .host_mode (host_mode),
    .pin_evt   (evt_alert_pin),
    .hdr_evt   (evt_alert_hdr),
    .alert_evt (alert_evt)
  );

  assign err_evt = {evt_bus_err, evt_arb_lost, evt_nack, evt_overrun,
                    evt_crc, evt_timeout, alert_evt};

  assign lvl_in = {lvl_start, lvl_addr_match, lvl_byte_done, lvl_hdr10,
                   lvl_stop, lvl_rx_full, lvl_tx_empty};

  genvar gi;
  generate
    for (gi = 0; gi < ERR_N; gi++) begin : g_err
      localparam int POS = err_pos(gi);
      i2c_sts_sticky #(
        .HW_CLR (err_hw_clr(gi))
      ) u_flag (
        .clk    (clk),
        .rst    (rst),
        .en     (periph_en),
        .evt    (err_evt[gi]),
        .sw_clr (wr_hit && !reg_wdata[POS]),
        .q      (err_q[gi])
      );
    end
  endgenerate

  i2c_sts_level_cap #(
    .W (LVL_N)
  ) u_lvl (
    .clk    (clk),
    .rst    (rst),
    .lvl_in (lvl_in),
    .lvl_q  (lvl_q)
  );

  always_comb begin
    sts_q = '0;
    for (int i = 0; i < ERR_N; i++) sts_q[err_pos(i)] = err_q[i];
    for (int j = 0; j < LVL_N; j++) sts_q[lvl_pos(j)] = lvl_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (rd_hit) reg_rdata <= sts_q;
    else             reg_rdata <= '0;
  end

endmodule

// File: rtl/i2c_evt_status_chk.sv
module i2c_evt_status_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h14
) (
  input logic              clk,
  input logic              rst,
  input logic              periph_en,
  input logic              evt_overrun,
  input logic              evt_nack,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [15:0]       reg_wdata,
  input logic              reg_rd,
  input logic [15:0]       reg_rdata,
  input logic [15:0]       sts_q
);
  logic hit_w;
  assign hit_w = reg_wr && (reg_addr == REG_OFS);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> reg_rdata == 16'h0000);

  // R2
  ovr_sets_chk: assert property (@(posedge clk) disable iff (rst)
    evt_overrun |=> sts_q[11]);

  // R3
  crc_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_q[12] && !(hit_w && !reg_wdata[12])) |=> sts_q[12]);

  // R4
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_nack && hit_w && !reg_wdata[10]) |=> sts_q[10]);

  // R7
  dis_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !periph_en |=> sts_q[15:14] == 2'b00);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[13] == 1'b0 && reg_rdata[5] == 1'b0);

  // R9
  miss_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != REG_OFS) |=> reg_rdata == 16'h0000);
endmodule

bind i2c_evt_status i2c_evt_status_chk #(
  .ADDR_W  (ADDR_W),
  .REG_OFS (REG_OFS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .periph_en   (periph_en),
  .evt_overrun (evt_overrun),
  .evt_nack    (evt_nack),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .sts_q       (sts_q)
);

// File: tb/sim_i2c_evt_status.sv
`timescale 1ns/1ps
module sim_i2c_evt_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic periph_en = 1'b1, host_mode = 1'b1;
  logic evt_alert_pin = 0, evt_alert_hdr = 0, evt_timeout = 0, evt_crc = 0;
  logic evt_overrun = 0, evt_nack = 0, evt_arb_lost = 0, evt_bus_err = 0;
  logic [6:0] lvl = '0; // {txe,rxne,stop,hdr10,done,addr,start}
  logic [7:0] reg_addr = 8'h14;
  logic reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  i2c_evt_status u0 (
    .clk(clk), .rst(rst), .periph_en(periph_en), .host_mode(host_mode),
    .evt_alert_pin(evt_alert_pin), .evt_alert_hdr(evt_alert_hdr),
    .evt_timeout(evt_timeout), .evt_crc(evt_crc), .evt_overrun(evt_overrun),
    .evt_nack(evt_nack), .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err),
    .lvl_tx_empty(lvl[6]), .lvl_rx_full(lvl[5]), .lvl_stop(lvl[4]),
    .lvl_hdr10(lvl[3]), .lvl_byte_done(lvl[2]), .lvl_addr_match(lvl[1]),
    .lvl_start(lvl[0]), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // entry: evt{alert,tmo,crc,ovr,nack,arb,berr}, lvl, wr, wdata, expected
  localparam int NV = 8;
  localparam logic [46:0] TBL [NV] = '{
    {7'b0001000, 7'b0000000, 1'b0, 16'h0000, 16'h0800}, // R2 overrun
    {7'b0000000, 7'b1000000, 1'b0, 16'h0000, 16'h0880}, // R2 sticky, R5
    {7'b0010001, 7'b1000000, 1'b0, 16'h0000, 16'h1980}, // R2 crc+berr
    {7'b0000000, 7'b0000000, 1'b1, 16'hF7FF, 16'h1100}, // R3 clear ovr only
    {7'b0000000, 7'b0000000, 1'b1, 16'hFFFF, 16'h1100}, // R3 ones keep
    {7'b0000100, 7'b0000000, 1'b1, 16'h0000, 16'h0400}, // R4 nack wins
    {7'b1100010, 7'b0100011, 1'b0, 16'h0000, 16'hC643}, // R6 host pin, R2
    {7'b0000000, 7'b1111111, 1'b1, 16'h0000, 16'h00DF}  // R5 R8 ro kept
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; reg_addr = 8'h14;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h14;
  endtask

  task automatic pulse(input logic [6:0] e, input logic hdr);
    @(negedge clk);
    {evt_alert_pin, evt_timeout, evt_crc, evt_overrun, evt_nack, evt_arb_lost, evt_bus_err} = e;
    evt_alert_hdr = hdr;
    @(negedge clk);
    {evt_alert_pin, evt_timeout, evt_crc, evt_overrun, evt_nack, evt_arb_lost, evt_bus_err} = '0;
    evt_alert_hdr = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    rd(8'h14, v); chk("R1 reset value", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {evt_alert_pin, evt_timeout, evt_crc, evt_overrun, evt_nack, evt_arb_lost, evt_bus_err} = TBL[i][46:40];
      lvl = TBL[i][39:33];
      reg_wr = TBL[i][32]; reg_wdata = TBL[i][31:16];
      @(negedge clk);
      {evt_alert_pin, evt_timeout, evt_crc, evt_overrun, evt_nack, evt_arb_lost, evt_bus_err} = '0;
      reg_wr = 0;
      rd(8'h14, v);
      chk($sformatf("R2/R3/R4/R5 table step %0d", i), v, TBL[i][15:0]);
      chk("R8 reserved bits", v & 16'h2020, 16'h0000);
    end
    lvl = '0;
    wr(8'h14, 16'h0000);

    // R6 device mode: pin ignored, header sets
    host_mode = 0;
    pulse(7'b1000000, 1'b0);
    rd(8'h14, v); chk("R6 pin ignored in device mode", v, 16'h0000);
    pulse(7'b0000000, 1'b1);
    rd(8'h14, v); chk("R6 header sets alert", v, 16'h8000);
    host_mode = 1;
    pulse(7'b0000000, 1'b1);
    wr(8'h14, 16'h7FFF);
    pulse(7'b0000000, 1'b1);
    rd(8'h14, v); chk("R6 header ignored in host mode", v, 16'h0000);

    // R7 disable clears alert/timeout only
    pulse(7'b1100001, 1'b0);
    rd(8'h14, v); chk("R7 before disable", v, 16'hC100);
    @(negedge clk); periph_en = 0;
    rd(8'h14, v); chk("R7 disable clears 15:14", v, 16'h0100);
    pulse(7'b1100000, 1'b0);
    rd(8'h14, v); chk("R7 events held off", v, 16'h0100);
    @(negedge clk); periph_en = 1;

    // R9 address decode
    wr(8'h10, 16'h0000);
    rd(8'h14, v); chk("R9 other address write ignored", v, 16'h0100);
    rd(8'h10, v); chk("R9 other address reads zero", v, 16'h0000);

    // R5 level follow
    @(negedge clk); lvl = 7'b0000001;
    rd(8'h14, v); chk("R5 start level seen", v, 16'h0101);
    @(negedge clk); lvl = 7'b0000000;
    rd(8'h14, v); chk("R5 start level dropped", v, 16'h0100);

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(8'h14, v); chk("R1 reset clears flags", v, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule